// File: doc/BRIEF.md
# Receive Queue Host Read Port

This block is a synchronous slave between an asynchronous parallel host bus and the read side of a receive data queue. The host marks a read by pulling both an active-low chip select and an active-low read strobe low. The two strobes may move in any order. The block brings the strobes into its own clock domain and finds where each read cycle starts and ends. It loads an output data register when a cycle starts and drives the data-bus enables for as long as the cycle lasts.

A queue-select input picks between two ways of handling a read. When it is high, the upper address lines are ignored and the read returns the word at the head of the queue. This lets a host that steps its address on every access still read the queue as a stream. When it is low, the address lines decode a small register file that holds the queue fill level and a status word. The data bus is normally 32 bits wide. A mode input narrows it to 16 bits, and the lowest address line then chooses which half-word is returned.

A queue word is popped at most once per read cycle, on the edge where the cycle ends. A read that would pop an empty queue returns zero and latches an underrun flag. Reading the status word clears that flag.

Top module: `hbus_rxq_port`

## Requirements
- R1: A read cycle is active only while cs_n and rd_n are both low, whichever of them falls first. With one strobe low on its own, oe_lo stays 0 and no pop occurs. oe_lo rises on the third rising clock edge after the second strobe falls. It falls on the third rising edge after the first strobe rises.
- R2: When fifo_sel is high at cycle start, addr[6:1] has no effect and dout returns fifo_head, in order, one word per cycle.
- R3: fifo_pop pulses for exactly one clock at the end of a cycle, and only when all three of these hold: fifo_sel was high, the queue was not empty, and either the bus was 32 bits wide (bus16=0) or addr[0]=1. No other cycle pops.
- R4: With bus16=1, oe_hi stays 0 and dout[31:16] is 0 for the whole cycle. dout[15:0] returns bits 15:0 of the selected word when addr[0]=0 and bits 31:16 when addr[0]=1. With bus16=0, oe_hi follows oe_lo.
- R5: A fifo_sel read of an empty queue returns 0. If that read would have popped under R3, it leaves fifo_pop low and sets the underrun flag.
- R6: With fifo_sel low, the register index is addr[6:1]. Index 1 returns fifo_level, zero-extended. Index 2 returns the status word: bit 0 is the underrun flag and bit 1 is the empty flag. Every other index reads 0.
- R7: A cycle that reads status index 2 clears the underrun flag when it ends, so the next status read shows bit 0 as 0.
- R8: dout holds the value loaded at cycle start while oe_lo is high, even if fifo_head changes during the cycle.
- R9: After reset, oe_lo, oe_hi and fifo_pop are 0 and the underrun flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| fifo_sel | input | 1 | High selects the queue alias; same timing as the address lines |
| addr | input | ADDR_W (7) | Host address A7..A1; addr[0] is A1 |
| bus16 | input | 1 | 1 selects the 16-bit data bus |
| fifo_head | input | DATA_W (32) | Word at the queue head |
| fifo_empty | input | 1 | Queue holds no word |
| fifo_level | input | LVL_W (8) | Number of words in the queue |
| fifo_pop | output | 1 | One-clock request to advance the queue head |
| dout | output | DATA_W (32) | Read data to the bus pads |
| oe_lo | output | 1 | Drive enable for dout[15:0] |
| oe_hi | output | 1 | Drive enable for dout[31:16] |

## Verification
The hardest state to reach from the ports is an underrun that has been set and then cleared. To get there, the bench first empties the queue with a series of aliased reads. Some of these use a 16-bit lower-half read, which must not pop. The next full-word alias read finds the queue empty, and two status reads follow: the first must show the flag set, the second must show it cleared. Cycle detection under either strobe order is checked the same way. Each read holds one strobe low for several clocks before the other arrives, and the bench watches for any early drive enable or pop in that window.

// File: rtl/hbus_rxq_pkg.sv
package hbus_rxq_pkg;
  // register indices decoded from addr[ADDR_W-1:1] when the queue alias is off
  localparam int unsigned IDX_LEVEL  = 1;
  localparam int unsigned IDX_STATUS = 2;
  // status word bit positions
  localparam int unsigned ST_UNDER   = 0;
  localparam int unsigned ST_EMPTY   = 1;
endpackage

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic busy,
  output logic start,
  output logic stop
);
  logic [STAGES-1:0] sh;
  logic              act;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], (~cs_n & ~rd_n)};
  end

  assign act   = sh[STAGES-1];
  assign start = act & ~busy;
  assign stop  = ~act & busy;
endmodule

// File: rtl/hbus_read_mux.sv
module hbus_read_mux
  import hbus_rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned LVL_W  = 8
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode16,
  input  logic [DATA_W-1:0] head,
  input  logic              empty,
  input  logic [LVL_W-1:0]  level,
  input  logic              underrun,
  output logic [DATA_W-1:0] word
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned IDXW = ADDR_W - 1;

  logic [DATA_W-1:0] full;
  logic [IDXW-1:0]   idx;

  assign idx = addr[ADDR_W-1:1];

  always_comb begin
    full = '0;
    if (sel) begin
      if (!empty) full = head;
    end else if (idx == IDXW'(IDX_LEVEL)) begin
      full[LVL_W-1:0] = level;
    end else if (idx == IDXW'(IDX_STATUS)) begin
      full[ST_UNDER] = underrun;
      full[ST_EMPTY] = empty;
    end
  end

  always_comb begin
    word = full;
    if (mode16) begin
      word = '0;
      word[HALF-1:0] = addr[0] ? full[DATA_W-1:HALF] : full[HALF-1:0];
    end
  end
endmodule

// File: rtl/hbus_rxq_port.sv
module hbus_rxq_port
  import hbus_rxq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned LVL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              fifo_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus16,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              fifo_empty,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_pop,
  output logic [DATA_W-1:0] dout,
  output logic              oe_lo,
  output logic              oe_hi
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned IDXW = ADDR_W - 1;

  logic              start, stop;
  logic [DATA_W-1:0] word;
  logic              underrun;
  logic              sel_l, mode_l, a1_l, empty_l, stat_l;
  logic              pops_here;

  hbus_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .rd_n  (rd_n),
    .busy  (oe_lo),
    .start (start),
    .stop  (stop)
  );

  hbus_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_mux (
    .sel      (fifo_sel),
    .addr     (addr),
    .mode16   (bus16),
    .head     (fifo_head),
    .empty    (fifo_empty),
    .level    (fifo_level),
    .underrun (underrun),
    .word     (word)
  );

  // a queue read consumes a word only on its last (or only) access
  assign pops_here = sel_l & (~mode_l | a1_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      oe_lo    <= 1'b0;
      oe_hi    <= 1'b0;
      fifo_pop <= 1'b0;
      underrun <= 1'b0;
      sel_l    <= 1'b0;
      mode_l   <= 1'b0;
      a1_l     <= 1'b0;
      empty_l  <= 1'b0;
      stat_l   <= 1'b0;
    end else begin
      fifo_pop <= 1'b0;
      if (start) begin
        dout    <= word;
        oe_lo   <= 1'b1;
        oe_hi   <= ~bus16;
        sel_l   <= fifo_sel;
        mode_l  <= bus16;
        a1_l    <= addr[0];
        empty_l <= fifo_empty;
        stat_l  <= (addr[ADDR_W-1:1] == IDXW'(IDX_STATUS));
      end else if (stop) begin
        oe_lo <= 1'b0;
        oe_hi <= 1'b0;
        if (pops_here) begin
          if (empty_l) underrun <= 1'b1;
          else         fifo_pop <= 1'b1;
        end else if (!sel_l && stat_l) begin
          underrun <= 1'b0;
        end
      end
    end
  end

  // R3: one pop per cycle, issued as the cycle closes
  a_r3_single_pop: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);
  a_r3_pop_at_end: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (!oe_lo && $past(oe_lo)));
  // R5: an underrun never coincides with a pop
  a_r5_no_pop_on_underrun: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> !fifo_pop);
  // R4: upper lane only with lower lane, and upper data zero in narrow mode
  a_r4_hi_with_lo: assert property (@(posedge clk) disable iff (rst)
    oe_hi |-> oe_lo);
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (oe_lo && mode_l) |-> (dout[DATA_W-1:HALF] == '0));
  // R8: data held while driven
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (oe_lo && $past(oe_lo)) |-> $stable(dout));
endmodule

// File: tb/hbus_rxq_port_bench.sv
module hbus_rxq_port_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, rd_n, fifo_sel, bus16;
  logic [6:0]  addr;
  logic [31:0] fifo_head;
  logic        fifo_empty;
  logic [7:0]  fifo_level;
  logic        fifo_pop;
  logic [31:0] dout;
  logic        oe_lo, oe_hi;

  logic [31:0] mem [16];
  int          rp = 0, wp = 0, pops = 0;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  assign fifo_head  = mem[rp % 16];
  assign fifo_empty = (wp == rp);
  assign fifo_level = 8'(wp - rp);

  always @(posedge clk) begin
    if (fifo_pop) begin
      rp   <= rp + 1;
      pops <= pops + 1;
    end
  end

  hbus_rxq_port u_hbus_rxq_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .fifo_sel(fifo_sel),
    .addr(addr), .bus16(bus16), .fifo_head(fifo_head), .fifo_empty(fifo_empty),
    .fifo_level(fifo_level), .fifo_pop(fifo_pop), .dout(dout),
    .oe_lo(oe_lo), .oe_hi(oe_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk);
    mem[wp % 16] = v;
    wp = wp + 1;
  endtask

  // one host read; checks R1 timing and R8 hold on the way
  task automatic rd(input logic sel, input logic [6:0] a, input bit rd_first,
                    input bit poke, output logic [31:0] d, output logic hi,
                    output int npop);
    int p0;
    p0 = pops;
    @(negedge clk); fifo_sel = sel; addr = a;
    @(negedge clk); if (rd_first) rd_n = 1'b0; else cs_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 single strobe no drive", {31'd0, oe_lo}, 32'd0);
    chk("R1 single strobe no pop", 32'(pops - p0), 32'd0);
    if (rd_first) cs_n = 1'b0; else rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 drive after both strobes", {31'd0, oe_lo}, 32'd1);
    d  = dout;
    hi = oe_hi;
    if (poke) mem[rp % 16] = ~mem[rp % 16];
    repeat (2) @(negedge clk);
    chk("R8 data held", dout, d);
    if (rd_first) cs_n = 1'b1; else rd_n = 1'b1;
    @(negedge clk);
    if (rd_first) rd_n = 1'b1; else cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 released after end", {31'd0, oe_lo}, 32'd0);
    npop = pops - p0;
  endtask

  task automatic t_reset();
    chk("R9 oe_lo reset", {31'd0, oe_lo}, 32'd0);
    chk("R9 oe_hi reset", {31'd0, oe_hi}, 32'd0);
    chk("R9 pop reset", {31'd0, fifo_pop}, 32'd0);
  endtask

  task automatic t_alias32();
    logic [31:0] d; logic hi; int np;
    bus16 = 1'b0;
    rd(1'b1, 7'h5A, 1'b0, 1'b0, d, hi, np);
    chk("R2 alias word 0", d, 32'hA1B2C3D4);
    chk("R4 wide upper lane", {31'd0, hi}, 32'd1);
    chk("R3 one pop wide", 32'(np), 32'd1);
    rd(1'b1, 7'h23, 1'b1, 1'b0, d, hi, np);
    chk("R2 alias word 1 other upper addr", d, 32'h11223344);
    chk("R3 one pop rd first", 32'(np), 32'd1);
  endtask

  task automatic t_regs();
    logic [31:0] d; logic hi; int np;
    bus16 = 1'b0;
    rd(1'b0, {6'd1, 1'b0}, 1'b0, 1'b0, d, hi, np);
    chk("R6 level register", d, 32'd2);
    chk("R3 register read no pop", 32'(np), 32'd0);
    rd(1'b0, {6'd5, 1'b0}, 1'b1, 1'b0, d, hi, np);
    chk("R6 unmapped reads zero", d, 32'd0);
    rd(1'b0, {6'd2, 1'b0}, 1'b0, 1'b0, d, hi, np);
    chk("R6 status not empty no underrun", d, 32'd0);
  endtask

  task automatic t_narrow();
    logic [31:0] d; logic hi; int np;
    bus16 = 1'b1;
    rd(1'b1, 7'h40, 1'b0, 1'b0, d, hi, np);
    chk("R4 lower half", d, 32'h0000BEEF);
    chk("R4 narrow upper lane off", {31'd0, hi}, 32'd0);
    chk("R3 lower half no pop", 32'(np), 32'd0);
    rd(1'b1, 7'h41, 1'b1, 1'b0, d, hi, np);
    chk("R4 upper half", d, 32'h0000DEAD);
    chk("R3 upper half pops", 32'(np), 32'd1);
  endtask

  task automatic t_hold();
    logic [31:0] d; logic hi; int np;
    bus16 = 1'b0;
    rd(1'b1, 7'h00, 1'b0, 1'b1, d, hi, np);
    chk("R8 word loaded at start", d, 32'h5555AAAA);
    chk("R3 pop after hold", 32'(np), 32'd1);
  endtask

  task automatic t_underrun();
    logic [31:0] d; logic hi; int np;
    bus16 = 1'b0;
    rd(1'b1, 7'h10, 1'b0, 1'b0, d, hi, np);
    chk("R5 empty read zero", d, 32'd0);
    chk("R5 empty read no pop", 32'(np), 32'd0);
    rd(1'b0, {6'd2, 1'b0}, 1'b1, 1'b0, d, hi, np);
    chk("R5 status underrun and empty", d, 32'd3);
    rd(1'b0, {6'd2, 1'b0}, 1'b0, 1'b0, d, hi, np);
    chk("R7 underrun cleared by status read", d, 32'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; fifo_sel = 1'b0; bus16 = 1'b0; addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    push(32'hA1B2C3D4);
    push(32'h11223344);
    push(32'hDEADBEEF);
    push(32'h5555AAAA);
    t_alias32();
    t_regs();
    t_narrow();
    t_hold();
    t_underrun();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule